// File: doc/BRIEF.md
# Low-Speed USB Edge-Interval Line Decoder

This block turns the differential data line of a low-speed USB link into a stream of decoded bits. It does not recover a bit clock and sample at a fixed phase. Instead it counts system clocks between successive J/K transitions. It rounds each count to a whole number of bit times and emits the bit run that the NRZI code implies for that gap. The timing restarts at every transition, so oscillator drift never builds up over a long packet.

The system clock runs at an integer multiple (`CLKS_PER_BIT`) of the 1.5 Mb/s bit rate. The synchronized line state is captured on the falling clock edge, which gives half a system clock of setup margin against the logic that drives it. Decoded runs are held in a small queue and replayed one bit per cycle on a bit/valid pair. The receiver reports two events on single-cycle strobes:
- a held SE0, as end of packet;
- a gap that exceeds what bit stuffing allows, as a stuffing violation.

Top module: `usb_ls_interval_rx`

## Requirements
- R1: The line code is 2'b10 = J, 2'b01 = K, 2'b00 = SE0 (2'b11 is neither a data level nor SE0). The line is captured on the falling clock edge.
- R2: While idle, the receiver starts timing on the first sample of K. This start transition produces no bits, and SYNC bits after it are decoded like any other data.
- R3: An interval of m clocks between J/K transitions is taken as k bit times, where k·C − C/2 ≤ m < k·C + C/2 and C = CLKS_PER_BIT. Intervals shorter than that for k = 1 count as one bit time.
- R4: An interval of k bit times is output as k−1 ones followed by one zero, first bit first, one bit per cycle with `bit_valid` high.
- R5: An SE0 lasting fewer than C consecutive samples does not end the packet and is not a transition. Its clocks count toward the interval in progress.
- R6: C consecutive SE0 samples during a packet give a one-cycle `eop_strobe`. The interval cut short by the SE0 produces no bits, and the receiver returns to idle. `eop_strobe` and `stuff_err` are never high together.
- R7: When the interval in progress reaches 8·C − C/2 clocks (7.5 bit times), the receiver:
  - pulses `stuff_err` for one cycle;
  - drops any queued bits;
  - ignores the line until it returns to J, and then goes back to idle.

  An interval of 8·C − C/2 − 1 clocks still decodes as 7 bit times.
- R8: While idle, SE0 and J produce no bits and no strobes.
- R9: After reset, `bit_valid`, `eop_strobe` and `stuff_err` are low.
- R10: The bits of successive intervals come out in the order the intervals occurred, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLKS_PER_BIT times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Synchronized line level: 10 J, 01 K, 00 SE0 |
| bit_out | output | 1 | Decoded data bit |
| bit_valid | output | 1 | `bit_out` carries a decoded bit this cycle |
| eop_strobe | output | 1 | One-cycle end-of-packet pulse |
| stuff_err | output | 1 | One-cycle pulse for an over-long run without a transition |

## Verification
A wrong interval count or a misplaced rounding threshold shows up as a run of the wrong length at the next transition. Every later bit of the packet then shifts, so the error appears in the decoded stream a few cycles after that edge. Faults in the SE0 counter or the overlong limit show up as an `eop_strobe` or `stuff_err` that arrives a cycle early, arrives late, or never arrives. A level-tracking fault, such as losing the last J/K level across an SE0 glitch, produces a spurious extra run that can be seen as soon as the line leaves SE0.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_K   = 2'b01,
        LN_J   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ACTIVE,
        RX_HOLD
    } rx_state_e;

    localparam int MAX_RUN = 7;

    typedef logic [2:0] run_len_t;

    typedef struct packed {
        logic     push;
        run_len_t len;
    } run_req_t;

    // Number of whole bit times an interval of m clocks stands for.
    function automatic run_len_t bits_in_interval(input int unsigned m, input int unsigned cpb);
        run_len_t n;
        n = 3'd1;
        for (int k = 2; k <= MAX_RUN; k++) begin
            if (m >= (k * cpb) - (cpb / 2)) n = run_len_t'(k);
        end
        return n;
    endfunction

endpackage

// File: rtl/usb_ls_line_sampler.sv
module usb_ls_line_sampler
    import usb_ls_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_in,
    output line_e      line_s
);
    // Captured on the falling edge: half a clock of margin to the launching edge (R1).
    always_ff @(negedge clk) begin
        if (rst) line_s <= LN_J;
        else     line_s <= line_e'(line_in);
    end
endmodule

// File: rtl/usb_ls_interval_timer.sv
module usb_ls_interval_timer
    import usb_ls_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  line_e    line_s,
    output run_req_t req,
    output logic     eop,
    output logic     err
);
    localparam int LIMIT = 8 * CLKS_PER_BIT - CLKS_PER_BIT / 2;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam int SE0_W = $clog2(CLKS_PER_BIT + 1);

    rx_state_e        state;
    line_e            last_lvl;
    logic [CNT_W-1:0] cnt;
    logic [SE0_W-1:0] se0_cnt;

    logic is_data, toggle, overlong;

    always_comb begin
        is_data  = (line_s == LN_J) || (line_s == LN_K);
        toggle   = is_data && (line_s != last_lvl);
        overlong = (cnt >= CNT_W'(LIMIT));
        req.push = (state == RX_ACTIVE) && toggle && !overlong;
        req.len  = bits_in_interval(int'(cnt), CLKS_PER_BIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            last_lvl <= LN_J;
            cnt      <= '0;
            se0_cnt  <= '0;
            eop      <= 1'b0;
            err      <= 1'b0;
        end else begin
            eop <= 1'b0;
            err <= 1'b0;
            case (state)
                RX_IDLE: begin
                    last_lvl <= LN_J;
                    se0_cnt  <= '0;
                    if (line_s == LN_K) begin
                        state    <= RX_ACTIVE;
                        last_lvl <= LN_K;
                        cnt      <= CNT_W'(1);
                    end
                end
                RX_ACTIVE: begin
                    if (line_s == LN_SE0) begin
                        if (se0_cnt == SE0_W'(CLKS_PER_BIT - 1)) begin
                            eop   <= 1'b1;
                            state <= RX_IDLE;
                        end else begin
                            se0_cnt <= se0_cnt + 1'b1;
                        end
                        if (!overlong) cnt <= cnt + 1'b1;
                    end else begin
                        se0_cnt <= '0;
                        if (overlong) begin
                            err   <= 1'b1;
                            state <= RX_HOLD;
                        end else if (toggle) begin
                            cnt      <= CNT_W'(1);
                            last_lvl <= line_s;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (line_s == LN_J) state <= RX_IDLE;
                end
            endcase
        end
    end

    assert_eop_pulse_R6: assert property (@(posedge clk) disable iff (rst) eop |=> !eop);
    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst) err |=> !err);
endmodule

// File: rtl/usb_ls_run_fifo.sv
module usb_ls_run_fifo
    import usb_ls_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     wr_en,
    input  run_len_t wr_data,
    input  logic     rd_en,
    output run_len_t rd_data,
    output logic     empty,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    run_len_t      mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en && !full) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (rd_en && !empty) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + (AW+1)'(wr_en && !full) - (AW+1)'(rd_en && !empty);
        end
    end
endmodule

// File: rtl/usb_ls_run_serializer.sv
module usb_ls_run_serializer
    import usb_ls_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     q_empty,
    input  run_len_t q_data,
    output logic     q_pop,
    output logic     bit_out,
    output logic     bit_valid
);
    run_len_t rem;

    assign q_pop = !flush && (rem == '0) && !q_empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rem       <= '0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else if (q_pop) begin
            bit_out   <= (q_data > 3'd1);
            bit_valid <= 1'b1;
            rem       <= run_len_t'(q_data - 3'd1);
        end else if (rem != '0) begin
            bit_out   <= (rem > 3'd1);
            bit_valid <= 1'b1;
            rem       <= run_len_t'(rem - 3'd1);
        end else begin
            bit_valid <= 1'b0;
        end
    end

    assert_popped_run_nonzero_R3: assert property (@(posedge clk) disable iff (rst) q_pop |-> (q_data != '0));
endmodule

// File: rtl/usb_ls_interval_rx.sv
module usb_ls_interval_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int CLKS_PER_BIT    = 8,
    parameter int RUN_QUEUE_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_state,
    output logic       bit_out,
    output logic       bit_valid,
    output logic       eop_strobe,
    output logic       stuff_err
);
    line_e    line_s;
    run_req_t req;
    run_len_t q_data;
    logic     q_empty, q_full, q_pop;

    usb_ls_line_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_state),
        .line_s  (line_s)
    );

    usb_ls_interval_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .line_s (line_s),
        .req    (req),
        .eop    (eop_strobe),
        .err    (stuff_err)
    );

    usb_ls_run_fifo #(.DEPTH(RUN_QUEUE_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .flush   (stuff_err),
        .wr_en   (req.push),
        .wr_data (req.len),
        .rd_en   (q_pop),
        .rd_data (q_data),
        .empty   (q_empty),
        .full    (q_full)
    );

    usb_ls_run_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .flush     (stuff_err),
        .q_empty   (q_empty),
        .q_data    (q_data),
        .q_pop     (q_pop),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst) req.push |-> !q_full);
    assert_eop_err_exclusive_R6: assert property (@(posedge clk) disable iff (rst) !(eop_strobe && stuff_err));
endmodule

// File: tb/usb_ls_interval_rx_bench.sv
module usb_ls_interval_rx_bench;
    localparam int CPB = 8;
    localparam logic [1:0] LJ = 2'b10, LK = 2'b01, LSE0 = 2'b00;
    // [31:28] interval count, nibble i = interval i in bit times
    localparam logic [31:0] PKT [5] = '{32'h73211111, 32'h50051432, 32'h40002617, 32'h30000111, 32'h40007244};
    localparam int JIT [5] = '{0, 3, 2, -3, 1};

    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] line = LJ;
    logic bit_out, bit_valid, eop_strobe, stuff_err;

    int checks = 0, errors = 0;
    int gcnt = 0, ecnt = 0, eop_cnt = 0, err_cnt = 0;
    logic got [512];
    logic expv [512];

    always #5 clk = ~clk;

    usb_ls_interval_rx #(.CLKS_PER_BIT(CPB)) u_usb_ls_interval_rx (
        .clk(clk), .rst(rst), .line_state(line),
        .bit_out(bit_out), .bit_valid(bit_valid),
        .eop_strobe(eop_strobe), .stuff_err(stuff_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid && gcnt < 512) begin got[gcnt] = bit_out; gcnt++; end
            if (eop_strobe) eop_cnt++;
            if (stuff_err) err_cnt++;
        end
    end

    task automatic drive(input logic [1:0] lvl, input int clks);
        line = lvl;
        repeat (clks) @(posedge clk);
        #1;
    endtask

    task automatic clear_obs();
        gcnt = 0; ecnt = 0; eop_cnt = 0; err_cnt = 0;
    endtask

    task automatic exp_run(input int n);
        for (int i = 0; i < n - 1; i++) begin expv[ecnt] = 1'b1; ecnt++; end
        expv[ecnt] = 1'b0; ecnt++;
    endtask

    task automatic check_int(input string tag, input int act, input int exp_i);
        checks++;
        if (act != exp_i) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp_i);
        end
    endtask

    task automatic check_seq(input string tag);
        int bad;
        bad = -1;
        check_int({tag, " bit count"}, gcnt, ecnt);
        for (int i = 0; i < ecnt && i < gcnt; i++) if (bad < 0 && got[i] != expv[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s bit %0d actual %0b expected %0b", tag, bad, got[bad], expv[bad]);
        end
    endtask

    task automatic send_eop();
        drive(LSE0, 2 * CPB);
        drive(LJ, 2 * CPB);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R10 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check_int("R9 bit_valid after reset", int'(bit_valid), 0);
        check_int("R9 eop after reset", int'(eop_strobe), 0);
        check_int("R9 stuff_err after reset", int'(stuff_err), 0);
        @(posedge clk); #1;

        // Vector table: R2 R3 R4 R6 R10
        for (int v = 0; v < 5; v++) begin
            logic [1:0] lvl;
            int n, d, len;
            clear_obs();
            drive(LJ, 10);
            lvl = LK;
            len = int'(PKT[v][31:28]);
            for (int i = 0; i < len; i++) begin
                n = int'(PKT[v][4*i +: 4]);
                d = (i % 2 == 0) ? JIT[v] : -JIT[v];
                drive(lvl, n * CPB + d);
                if (i < len - 1) exp_run(n);
                lvl = (lvl == LK) ? LJ : LK;
            end
            send_eop();
            check_seq($sformatf("R4 R10 vector %0d", v));
            check_int($sformatf("R6 vector %0d eop count", v), eop_cnt, 1);
            check_int($sformatf("R7 vector %0d no stuff error", v), err_cnt, 0);
        end

        // R3 band edges: 11 clocks -> 1 bit, 12 -> 2, 20 -> 3
        clear_obs();
        drive(LJ, 10); drive(LK, 11); drive(LJ, 12); drive(LK, 20); drive(LJ, 19);
        send_eop();
        exp_run(1); exp_run(2); exp_run(3);
        check_seq("R3 band edges");

        // R5 SE0 glitch of C-1 samples inside an interval: 16+7+8 = 31 clocks -> 4 bits
        clear_obs();
        drive(LJ, 10); drive(LK, 16); drive(LSE0, CPB - 1); drive(LK, 8); drive(LJ, 8);
        check_int("R5 no eop on short SE0", eop_cnt, 0);
        send_eop();
        exp_run(4);
        check_seq("R5 glitch bridged");
        check_int("R5 R6 single eop", eop_cnt, 1);

        // R8 idle SE0 ignored
        clear_obs();
        drive(LJ, 10); drive(LSE0, 20); drive(LJ, 20);
        check_int("R8 no bits in idle", gcnt, 0);
        check_int("R8 no eop in idle", eop_cnt, 0);
        check_int("R8 no error in idle", err_cnt, 0);

        // R7 longest legal run (59 clocks -> 7 bits) then overlong K
        clear_obs();
        drive(LJ, 10); drive(LK, 16); drive(LJ, 59); drive(LK, 72);
        check_int("R7 error on overlong", err_cnt, 1);
        drive(LJ, 10);
        exp_run(2); exp_run(7);
        check_seq("R7 bits before abort");
        check_int("R7 no eop after abort", eop_cnt, 0);

        // R7 exact limit: 60 clocks is an error, not a run
        clear_obs();
        drive(LJ, 10); drive(LK, 8); drive(LJ, 60); drive(LK, 20);
        drive(LJ, 10);
        exp_run(1);
        check_seq("R7 limit boundary");
        check_int("R7 limit error count", err_cnt, 1);

        // R2 recovery after abort, new packet starts cleanly
        clear_obs();
        drive(LJ, 10); drive(LK, 8); drive(LJ, 16); drive(LK, 8);
        send_eop();
        exp_run(1); exp_run(2);
        check_seq("R2 restart after abort");
        check_int("R2 eop after restart", eop_cnt, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule